// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block watches the destination address of each incoming frame, one byte per strobe, and decides whether the frame should be kept. Four filters are applied. A frame sent to every station is kept or dropped according to a mode input. Group-addressed frames are checked against a 64-entry hash table indexed by a CRC of the address. Individually addressed frames are kept only if they match the programmed station address. A promiscuous override keeps every frame but still reports whether the address filter missed.

The receive path marks the first address byte of each frame with a start flag and presents the following bytes with a valid strobe. Gaps between bytes are allowed. One clock after the sixth byte, a single-cycle decision strobe is raised. The keep and miss results are then held until the first byte of the next frame arrives. Bytes that follow the sixth are not looked at.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After reset, `dec_vld`, `accept` and `miss` are 0, and bytes presented without `first` are ignored until a byte with `first` arrives.
- R2: A byte with both `byte_vld` and `first` high is address byte 0 of a new frame, even if an earlier frame is unfinished. In the cycle after it, `accept` and `miss` read 0. Only cycles with `byte_vld` high advance the byte count, so idle cycles between bytes change nothing.
- R3: `dec_vld` is high for exactly one cycle, the cycle after address byte 5 (the sixth) is taken. `accept` and `miss` take their new values in that same cycle and hold them until the next `first` byte. Bytes after the sixth do not alter them.
- R4: When all six bytes are 0xFF the address is broadcast: `miss` equals `rej_bcast`. This case takes precedence over the hash and unicast checks.
- R5: A non-broadcast address whose byte 0 has bit 0 set, or any non-broadcast address while `hash_all` is high, is hash filtered. `miss` is the inverse of the selected table bit, and the unicast compare is not used.
- R6: The hash is a 32-bit CRC that starts at 0xFFFFFFFF and runs over bytes 0 to 5, bit 0 of each byte first. Each step sets c = crc[31] XOR bit, shifts crc left by one, and XORs with 0x04C11DB7 when c is 1. The table index is bits 31:26 of the final CRC.
- R7: Index values 0 to 31 select bit `index` of `hash_lo`, and index values 32 to 63 select bit `index-32` of `hash_hi`.
- R8: Any other address is unicast. It hits only if byte 0 = `station_hi[15:8]`, byte 1 = `station_hi[7:0]`, byte 2 = `station_lo[31:24]`, byte 3 = `station_lo[23:16]`, byte 4 = `station_lo[15:8]` and byte 5 = `station_lo[7:0]`. Otherwise `miss` is 1.
- R9: `accept` = NOT `miss` OR `promisc`. With `promisc` high, a missed frame is accepted and `miss` still reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | Address byte strobe |
| first | input | 1 | Marks byte 0 of a frame (qualified by byte_vld) |
| byte_data | input | 8 | Address byte |
| rej_bcast | input | 1 | Treat broadcast as a miss |
| hash_all | input | 1 | Hash filter every non-broadcast address |
| promisc | input | 1 | Accept missed frames, still flag miss |
| station_hi | input | 16 | Station address bytes 0 and 1 |
| station_lo | input | 32 | Station address bytes 2 to 5 |
| hash_lo | input | 32 | Hash table entries 0 to 31 |
| hash_hi | input | 32 | Hash table entries 32 to 63 |
| dec_vld | output | 1 | One-cycle decision strobe |
| accept | output | 1 | Keep the frame |
| miss | output | 1 | Address filter missed |

## Verification
Each byte is driven on a falling edge and captured on the next rising edge. For every frame the bench checks `dec_vld`, `accept` and `miss` on the falling edge that follows the capture of the sixth byte. It checks them again one cycle later, when the strobe must have dropped and the results must be unchanged. The clearing effect of a start byte is due one cycle after it is captured and is sampled on the falling edge that follows. Expected hash bits come from the bench's own bit-serial CRC, which selects the table entries so that both halves of the table are exercised.

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter #(
  parameter logic [31:0] POLY     = 32'h04C11DB7,
  parameter logic [31:0] CRC_INIT = 32'hFFFF_FFFF,
  parameter int          NBYTES   = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld,
  input  logic        first,
  input  logic [7:0]  byte_data,
  input  logic        rej_bcast,
  input  logic        hash_all,
  input  logic        promisc,
  input  logic [15:0] station_hi,
  input  logic [31:0] station_lo,
  input  logic [31:0] hash_lo,
  input  logic [31:0] hash_hi,
  output logic        dec_vld,
  output logic        accept,
  output logic        miss
);
  localparam int CW = $clog2(NBYTES + 1);
  localparam logic [CW-1:0] IDLE = CW'(NBYTES);
  localparam logic [CW-1:0] LAST = CW'(NBYTES - 1);

  logic [CW-1:0] cnt;
  logic [31:0]   crc;
  logic          bc, uc, mc;

  function automatic logic [31:0] crc_step8(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[31] ^ d[i]) ? ((r << 1) ^ POLY) : (r << 1);
    return r;
  endfunction

  logic [CW-1:0] idx;
  logic          take, last;
  logic [31:0]   crc_nx;
  logic          bc_nx, uc_nx, mc_nx;
  logic [7:0]    want;
  logic [5:0]    hidx;
  logic          hbit, miss_c;

  assign take = byte_vld && (first || cnt < IDLE);
  assign idx  = first ? '0 : cnt;
  assign last = take && idx == LAST;

  always_comb begin
    case (idx)
      3'd0:    want = station_hi[15:8];
      3'd1:    want = station_hi[7:0];
      3'd2:    want = station_lo[31:24];
      3'd3:    want = station_lo[23:16];
      3'd4:    want = station_lo[15:8];
      default: want = station_lo[7:0];
    endcase
  end

  assign crc_nx = crc_step8(first ? CRC_INIT : crc, byte_data);
  assign bc_nx  = (first ? 1'b1 : bc) && byte_data == 8'hFF;
  assign uc_nx  = (first ? 1'b1 : uc) && byte_data == want;
  assign mc_nx  = first ? byte_data[0] : mc;
  assign hidx   = crc_nx[31:26];
  assign hbit   = hidx[5] ? hash_hi[hidx[4:0]] : hash_lo[hidx[4:0]];
  assign miss_c = bc_nx ? rej_bcast : (mc_nx || hash_all) ? !hbit : !uc_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= IDLE;
      crc     <= CRC_INIT;
      bc      <= 1'b0;
      uc      <= 1'b0;
      mc      <= 1'b0;
      dec_vld <= 1'b0;
      accept  <= 1'b0;
      miss    <= 1'b0;
    end else begin
      dec_vld <= last;
      if (take) begin
        cnt <= idx + 1'b1;
        crc <= crc_nx;
        bc  <= bc_nx;
        uc  <= uc_nx;
        mc  <= mc_nx;
      end
      if (take && first) begin
        accept <= 1'b0;
        miss   <= 1'b0;
      end
      if (last) begin
        accept <= !miss_c || promisc;
        miss   <= miss_c;
      end
    end
  end
endmodule

module eth_rx_addr_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_vld,
  input logic first,
  input logic promisc,
  input logic dec_vld,
  input logic accept,
  input logic miss
);
  // R3
  strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |=> !dec_vld);

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && first) |=> (!accept && !miss && !dec_vld));

  // R3
  result_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_vld && first) |=> (dec_vld || ($stable(accept) && $stable(miss))));

  // R9
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && !miss) |-> accept);

  // R9
  miss_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !first && !promisc) |=> !(dec_vld && miss && accept));

  // R1
  idle_after_reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!dec_vld && !accept && !miss));
endmodule

bind eth_rx_addr_filter eth_rx_addr_filter_chk u_chk (.*);

// File: tb/test_eth_rx_addr_filter.sv
module test_eth_rx_addr_filter;
  logic        clk = 0, rst_n = 0;
  logic        byte_vld = 0, first = 0;
  logic [7:0]  byte_data = 0;
  logic        rej_bcast = 0, hash_all = 0, promisc = 0;
  logic [15:0] station_hi = 16'h0A1B;
  logic [31:0] station_lo = 32'h2C3D4E5F;
  logic [31:0] hash_lo = 0, hash_hi = 0;
  logic        dec_vld, accept, miss;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  eth_rx_addr_filter i_eth_rx_addr_filter (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] hash_of(logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] d = a[47-8*b -: 8];
      for (int j = 0; j < 8; j++) begin
        logic cy = c[31] ^ d[j];
        c = c << 1;
        if (cy) c = (c ^ 32'h04C11DB6) | 32'h1;
      end
    end
    return c[31:26];
  endfunction

  task automatic put(logic [7:0] d, logic f);
    byte_vld = 1; first = f; byte_data = d;
    @(negedge clk);
    byte_vld = 0; first = 0; byte_data = 8'h00;
  endtask

  task automatic send(logic [47:0] a, bit gaps);
    for (int b = 0; b < 6; b++) begin
      if (gaps) @(negedge clk);
      put(a[47-8*b -: 8], b == 0);
    end
  endtask

  task automatic expect_dec(string req, logic exp_acc, logic exp_miss);
    chk(req, "dec_vld", dec_vld, 1);
    chk(req, "accept", accept, exp_acc);
    chk(req, "miss", miss, exp_miss);
    @(negedge clk);
    chk("R3", "dec_vld drop", dec_vld, 0);
    chk("R3", "accept hold", accept, exp_acc);
    chk("R3", "miss hold", miss, exp_miss);
  endtask

  task automatic t_reset;
    chk("R1", "dec_vld", dec_vld, 0);
    chk("R1", "accept", accept, 0);
    chk("R1", "miss", miss, 0);
    for (int i = 0; i < 8; i++) put(8'h0A, 0);
    @(negedge clk);
    chk("R1", "no frame dec_vld", dec_vld, 0);
    chk("R1", "no frame accept", accept, 0);
  endtask

  task automatic t_bcast;
    rej_bcast = 0; send(48'hFFFFFFFFFFFF, 0); expect_dec("R4", 1, 0);
    rej_bcast = 1; hash_lo = '1; hash_hi = '1;
    send(48'hFFFFFFFFFFFF, 0); expect_dec("R4", 0, 1);
    promisc = 1; send(48'hFFFFFFFFFFFF, 1); expect_dec("R9", 1, 1);
    promisc = 0; rej_bcast = 0; hash_lo = 0; hash_hi = 0;
  endtask

  task automatic t_unicast;
    send(48'h0A1B2C3D4E5F, 0); expect_dec("R8", 1, 0);
    send(48'h0A1B2C3D4E5E, 0); expect_dec("R8", 0, 1);
    send(48'h0B1B2C3D4E5F, 1); expect_dec("R8", 0, 1);
    send(48'h0A1B2C3C4E5F, 0); expect_dec("R8", 0, 1);
    promisc = 1; send(48'h0A1B2C3D4E5E, 0); expect_dec("R9", 1, 1);
    send(48'h0A1B2C3D4E5F, 0); expect_dec("R9", 1, 0);
    promisc = 0;
  endtask

  task automatic t_hash;
    logic [47:0] lo_a = 0, hi_a = 0;
    bit got_lo = 0, got_hi = 0;
    for (int k = 0; k < 256; k++) begin
      logic [47:0] a = {40'h01005E0000, 8'(k)};
      if (!got_lo && hash_of(a) < 32) begin lo_a = a; got_lo = 1; end
      if (!got_hi && hash_of(a) >= 32) begin hi_a = a; got_hi = 1; end
    end
    hash_lo = 32'h1 << hash_of(lo_a); hash_hi = 0;
    send(lo_a, 0); expect_dec("R7", 1, 0);
    hash_lo = ~(32'h1 << hash_of(lo_a)); hash_hi = '1;
    send(lo_a, 0); expect_dec("R6", 0, 1);
    hash_hi = 32'h1 << (hash_of(hi_a) - 32); hash_lo = 0;
    send(hi_a, 1); expect_dec("R7", 1, 0);
    hash_hi = ~(32'h1 << (hash_of(hi_a) - 32)); hash_lo = '1;
    send(hi_a, 0); expect_dec("R5", 0, 1);
    hash_all = 1; hash_lo = 0; hash_hi = 0;
    send(48'h0A1B2C3D4E5F, 0); expect_dec("R5", 0, 1);
    if (hash_of(48'h0A1B2C3D4E5F) >= 32) hash_hi = 32'h1 << (hash_of(48'h0A1B2C3D4E5F) - 32);
    else hash_lo = 32'h1 << hash_of(48'h0A1B2C3D4E5F);
    send(48'h0A1B2C3D4E5F, 0); expect_dec("R5", 1, 0);
    hash_all = 0; hash_lo = 0; hash_hi = 0;
  endtask

  task automatic t_sequence;
    send(48'h0A1B2C3D4E5F, 0); expect_dec("R3", 1, 0);
    for (int i = 0; i < 6; i++) put(8'hEE, 0);
    @(negedge clk);
    chk("R3", "trailing bytes dec_vld", dec_vld, 0);
    chk("R3", "trailing bytes accept", accept, 1);
    put(8'h0A, 1);
    chk("R2", "start clears accept", accept, 0);
    chk("R2", "start clears miss", miss, 0);
    put(8'h1B, 0); put(8'h2C, 0);
    send(48'h0A1B2C3D4E5E, 0); expect_dec("R2", 0, 1);
    put(8'h0A, 1); put(8'h1B, 0);
    for (int i = 0; i < 3; i++) @(negedge clk);
    put(8'h2C, 0); put(8'h3D, 0); put(8'h4E, 0);
    chk("R2", "no early dec", dec_vld, 0);
    put(8'h5F, 0); expect_dec("R2", 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_bcast;
    t_unicast;
    t_hash;
    t_sequence;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule